// File: doc/BRIEF.md
# Peripheral Request Stall Timer

This block watches one peripheral-paced transfer channel and reports when the peripheral has gone quiet. A free-running prescaler divides the clock by one of three selectable powers of two, and a period counter counts the resulting coarse ticks up to a selectable limit of 4 to 512. If the channel is enabled and no request is serviced before the period counter reaches its limit, the block raises a sticky stall flag and emits a single-cycle stall pulse.

Each serviced request restarts both counters from zero. The timer can start counting as soon as the channel is enabled, or it can stay idle until the first request has been serviced, so that a channel whose peripheral has not yet started is not reported. Disabling the channel returns the timer to its idle state but leaves a stall already recorded in the flag, which software clears with a write-one pulse.

Top module: `req_stall_timer`

## Requirements
- R1: After reset `stall_flag` and `stall_pulse` are 0.
- R2: With `tick_sel` = 0 the timer is off: no stall is ever reported and both counters sit at zero.
- R3: With `tick_sel` = 1, 2, 3 the clock is divided by 2^DIV_LOG2_A, 2^DIV_LOG2_B, 2^DIV_LOG2_C; `span_sel` = k (0..7) sets a limit of 4·2^k ticks. A stall is reported after exactly divisor × limit counted clock edges with no serviced request, `stall_pulse` and `stall_flag` going high after the edge that completes the count.
- R4: A cycle with `req_served` high clears the prescaler and period counters and restarts the count from the next edge.
- R5: With `await_first` = 1 the timer does not count after enabling until the first serviced request.
- R6: With `await_first` = 0 counting begins on the first clock edge at which `chan_on` is high.
- R7: `stall_flag` stays set until a cycle with `stall_ack` high; if a new stall coincides with `stall_ack`, the flag stays set.
- R8: `stall_pulse` is high for one cycle only, and only on the first stall after each restart; after a stall the timer stops until the next serviced request or re-enable.
- R9: With `chan_on` low the counters and the start condition are reset, while `stall_flag` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_on | input | 1 | Channel enable |
| req_served | input | 1 | One-cycle pulse per serviced transfer request |
| await_first | input | 1 | 1: hold off until first serviced request |
| tick_sel | input | 2 | Prescaler select: 0 off, 1..3 divider choices |
| span_sel | input | 3 | Period select: limit 4·2^span_sel ticks |
| stall_ack | input | 1 | Write-one clear of the stall flag |
| stall_flag | output | 1 | Sticky stall indication |
| stall_pulse | output | 1 | One-cycle pulse on a stall |

## Verification
The bench targets the exact expiry cycle for several prescaler and period pairs, including the largest period; an off-by-one terminal count would move the pulse by a whole tick and show up against the reference model. Requests served just before expiry must hold the pulse off, and a design that cleared only one of the two counters would expire early. Wait mode is held for a long idle stretch before the first request, so a timer that armed on enable would fire. Repeated expiry is watched after the first pulse, a coinciding clear and set is driven, and a disable after a stall is checked to keep the flag while a design that cleared it on disable would drop it.

// File: rtl/rst_pkg.sv
package rst_pkg;
   typedef logic [1:0] tick_sel_t;
   typedef logic [2:0] span_sel_t;
   localparam int SPAN_BITS = 3;
   localparam int BASE_LIMIT = 4;
   localparam int MAX_LIMIT = BASE_LIMIT << ((1 << SPAN_BITS) - 1);
   localparam int SPAN_CW = $clog2(MAX_LIMIT + 1);
endpackage

// File: rtl/rst_start_ctl.sv
module rst_start_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic chan_on,
   input  logic req_served,
   input  logic await_first,
   input  logic expire,
   output logic run,
   output logic restart
);
   logic seen_q;
   logic done_q;

   assign restart = !chan_on || req_served;
   assign run     = chan_on && !req_served && !done_q && (seen_q || !await_first);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= 1'b0;
         done_q <= 1'b0;
      end else if (!chan_on) begin
         seen_q <= 1'b0;
         done_q <= 1'b0;
      end else if (req_served) begin
         seen_q <= 1'b1;
         done_q <= 1'b0;
      end else if (expire) begin
         done_q <= 1'b1;
      end
   end
endmodule

// File: rtl/rst_prescaler.sv
module rst_prescaler #(
   parameter int DIV_LOG2_A = 8,
   parameter int DIV_LOG2_B = 16,
   parameter int DIV_LOG2_C = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              run,
   input  rst_pkg::tick_sel_t tick_sel,
   output logic              tick
);
   localparam int W = DIV_LOG2_C;

   logic [W-1:0] cnt_q;
   logic [W-1:0] term_tab [4];
   logic [W-1:0] term;

   assign term_tab[0] = '0;
   for (genvar g = 1; g < 4; g++) begin : g_term
      localparam int SH = (g == 1) ? DIV_LOG2_A : (g == 2) ? DIV_LOG2_B : DIV_LOG2_C;
      assign term_tab[g] = {W{1'b1}} >> (W - SH);
   end

   assign term = term_tab[tick_sel];
   assign tick = run && (tick_sel != 2'd0) && (cnt_q == term);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            cnt_q <= '0;
      else if (restart || tick_sel == 2'd0)  cnt_q <= '0;
      else if (run)                          cnt_q <= tick ? '0 : cnt_q + 1'b1;
   end
endmodule

// File: rtl/rst_span_counter.sv
module rst_span_counter (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              off,
   input  logic              tick,
   input  rst_pkg::span_sel_t span_sel,
   output logic              expire
);
   localparam int CW = rst_pkg::SPAN_CW;

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] limit;

   assign limit  = CW'(rst_pkg::BASE_LIMIT) << span_sel;
   assign expire = tick && (cnt_q >= limit - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (restart || off) cnt_q <= '0;
      else if (tick)           cnt_q <= expire ? '0 : cnt_q + 1'b1;
   end
endmodule

// File: rtl/req_stall_timer.sv
module req_stall_timer #(
   parameter int DIV_LOG2_A = 8,
   parameter int DIV_LOG2_B = 16,
   parameter int DIV_LOG2_C = 24
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       chan_on,
   input  logic       req_served,
   input  logic       await_first,
   input  logic [1:0] tick_sel,
   input  logic [2:0] span_sel,
   input  logic       stall_ack,
   output logic       stall_flag,
   output logic       stall_pulse
);
   initial begin
      assert (DIV_LOG2_A >= 1) else $error("DIV_LOG2_A must be at least 1");
      assert (DIV_LOG2_A < DIV_LOG2_B && DIV_LOG2_B < DIV_LOG2_C)
         else $error("divider choices must be strictly increasing");
      assert (DIV_LOG2_C <= 31) else $error("DIV_LOG2_C too large");
   end

   logic run;
   logic restart;
   logic tick;
   logic expire;

   rst_start_ctl u_start (
      .clk(clk), .rst_n(rst_n), .chan_on(chan_on), .req_served(req_served),
      .await_first(await_first), .expire(expire), .run(run), .restart(restart)
   );

   rst_prescaler #(
      .DIV_LOG2_A(DIV_LOG2_A), .DIV_LOG2_B(DIV_LOG2_B), .DIV_LOG2_C(DIV_LOG2_C)
   ) u_pre (
      .clk(clk), .rst_n(rst_n), .restart(restart), .run(run),
      .tick_sel(tick_sel), .tick(tick)
   );

   rst_span_counter u_span (
      .clk(clk), .rst_n(rst_n), .restart(restart), .off(tick_sel == 2'd0),
      .tick(tick), .span_sel(span_sel), .expire(expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stall_flag  <= 1'b0;
         stall_pulse <= 1'b0;
      end else begin
         stall_pulse <= expire;
         if (expire)         stall_flag <= 1'b1;
         else if (stall_ack) stall_flag <= 1'b0;
      end
   end
endmodule

// File: rtl/rst_checker.sv
module rst_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       chan_on,
   input logic [1:0] tick_sel,
   input logic       stall_ack,
   input logic       stall_flag,
   input logic       stall_pulse
);
   p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_sel == 2'd0) |=> !stall_pulse);
   p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stall_pulse |=> !stall_pulse);
   p_pulse_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stall_pulse |-> stall_flag);
   p_flag_rise_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stall_flag) |-> stall_pulse);
   p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_flag && !stall_ack) |=> stall_flag);
   p_idle_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_on |=> !stall_pulse);
endmodule

bind req_stall_timer rst_checker u_chk (
   .clk(clk), .rst_n(rst_n), .chan_on(chan_on), .tick_sel(tick_sel),
   .stall_ack(stall_ack), .stall_flag(stall_flag), .stall_pulse(stall_pulse)
);

// File: tb/sim_req_stall_timer.sv
`timescale 1ns/1ps
module sim_req_stall_timer;
   localparam int LA = 2, LB = 3, LC = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic chan_on = 1'b0, req_served = 1'b0, await_first = 1'b0, stall_ack = 1'b0;
   logic [1:0] tick_sel = 2'd0;
   logic [2:0] span_sel = 3'd0;
   logic stall_flag, stall_pulse;

   always #4 clk = ~clk;

   req_stall_timer #(.DIV_LOG2_A(LA), .DIV_LOG2_B(LB), .DIV_LOG2_C(LC)) u0 (
      .clk(clk), .rst_n(rst_n), .chan_on(chan_on), .req_served(req_served),
      .await_first(await_first), .tick_sel(tick_sel), .span_sel(span_sel),
      .stall_ack(stall_ack), .stall_flag(stall_flag), .stall_pulse(stall_pulse)
   );

   int total = 0, bad = 0;
   string cur_req = "R1";

   function automatic int divisor(input logic [1:0] s);
      case (s)
         2'd1: return 1 << LA;
         2'd2: return 1 << LB;
         2'd3: return 1 << LC;
         default: return 0;
      endcase
   endfunction

   // behavioural reference: one integer count of counted edges
   int  m_cnt = 0;
   bit  m_seen = 0, m_done = 0, m_flag = 0, m_pulse = 0;
   always @(posedge clk) begin
      bit e;
      e = 0;
      if (!rst_n) begin
         m_cnt = 0; m_seen = 0; m_done = 0; m_flag = 0; m_pulse = 0;
      end else begin
         if (!chan_on) begin
            m_cnt = 0; m_seen = 0; m_done = 0;
         end else if (req_served) begin
            m_cnt = 0; m_seen = 1; m_done = 0;
         end else if (tick_sel == 2'd0) begin
            m_cnt = 0;
         end else if ((m_seen || !await_first) && !m_done) begin
            m_cnt++;
            if (m_cnt == divisor(tick_sel) * (4 << span_sel)) begin
               e = 1; m_done = 1; m_cnt = 0;
            end
         end
         m_pulse = e;
         if (e) m_flag = 1;
         else if (stall_ack) m_flag = 0;
      end
   end

   task automatic check(input string req, input logic act, input logic exp, input string what);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) if (rst_n) begin
      check(cur_req, stall_flag, m_flag, "model flag");
      check(cur_req, stall_pulse, m_pulse, "model pulse");
   end

   task automatic idle_off();
      chan_on = 0; req_served = 0; stall_ack = 1;
      @(negedge clk); stall_ack = 0; @(negedge clk);
   endtask

   // counts negedges after start until pulse, up to lim
   task automatic wait_pulse(input int lim, output int n);
      n = 0;
      while (n < lim) begin
         @(negedge clk); n++;
         if (stall_pulse) return;
      end
      n = -1;
   endtask

   task automatic run_expiry(input string req, input logic [1:0] ts, input logic [2:0] ss);
      int n, expn;
      cur_req = req;
      idle_off();
      tick_sel = ts; span_sel = ss; await_first = 0; chan_on = 1;
      expn = divisor(ts) * (4 << ss);
      wait_pulse(expn + 10, n);
      total++;
      if (n != expn) begin
         bad++;
         $display("FAIL %s expiry cycles actual=%0d expected=%0d", req, n, expn);
      end
   endtask

   initial begin
      int n;
      fork
         begin
            repeat (3) @(negedge clk);
            check("R1", stall_flag, 1'b0, "flag in reset");
            check("R1", stall_pulse, 1'b0, "pulse in reset");
            rst_n = 1;
            @(negedge clk);
            check("R1", stall_flag, 1'b0, "flag after reset");

            // R6 and R3: immediate start, several selections
            run_expiry("R6", 2'd1, 3'd0);
            run_expiry("R3", 2'd2, 3'd1);
            run_expiry("R3", 2'd3, 3'd2);
            run_expiry("R3", 2'd1, 3'd7);

            // R8: no second pulse after a stall without restart
            cur_req = "R8";
            repeat (200) @(negedge clk);
            check("R8", stall_pulse, 1'b0, "no repeat pulse");
            check("R8", stall_flag, 1'b1, "flag held");

            // R9: disable keeps flag
            cur_req = "R9";
            chan_on = 0;
            repeat (5) @(negedge clk);
            check("R9", stall_flag, 1'b1, "flag kept on disable");

            // R7: ack clears; coinciding set wins
            cur_req = "R7";
            stall_ack = 1; @(negedge clk); stall_ack = 0;
            check("R7", stall_flag, 1'b0, "flag cleared by ack");
            tick_sel = 2'd1; span_sel = 3'd0; chan_on = 1;
            repeat (15) @(negedge clk);
            stall_ack = 1; @(negedge clk); stall_ack = 0;
            check("R7", stall_pulse, 1'b1, "pulse with ack");
            check("R7", stall_flag, 1'b1, "set wins over ack");

            // R4: requests every 14 cycles keep it quiet (limit 16)
            cur_req = "R4";
            idle_off();
            tick_sel = 2'd1; span_sel = 3'd0; chan_on = 1;
            for (int k = 0; k < 10; k++) begin
               repeat (13) @(negedge clk);
               req_served = 1; @(negedge clk); req_served = 0;
            end
            check("R4", stall_flag, 1'b0, "no stall with regular requests");
            wait_pulse(40, n);
            total++;
            if (n != 16) begin
               bad++;
               $display("FAIL R4 cycles after last request actual=%0d expected=16", n);
            end

            // R5: wait mode holds off until first request
            cur_req = "R5";
            idle_off();
            tick_sel = 2'd1; span_sel = 3'd0; await_first = 1; chan_on = 1;
            repeat (300) @(negedge clk);
            check("R5", stall_flag, 1'b0, "idle before first request");
            req_served = 1; @(negedge clk); req_served = 0;
            wait_pulse(40, n);
            total++;
            if (n != 16) begin
               bad++;
               $display("FAIL R5 cycles after first request actual=%0d expected=16", n);
            end

            // R2: prescaler off
            cur_req = "R2";
            idle_off();
            await_first = 0; tick_sel = 2'd0; span_sel = 3'd0; chan_on = 1;
            repeat (2000) @(negedge clk);
            check("R2", stall_flag, 1'b0, "no stall when off");
            // switching on later counts from zero
            tick_sel = 2'd1;
            wait_pulse(40, n);
            total++;
            if (n != 16) begin
               bad++;
               $display("FAIL R2 cycles after enabling prescaler actual=%0d expected=16", n);
            end
            idle_off();
         end
         begin
            repeat (100000) @(posedge clk);
            total++; bad++;
            $display("FAIL watchdog expired actual=hang expected=finish");
         end
      join_any
      disable fork;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule